// File: doc/BRIEF.md
# Overlapping Register Window File

This block is the general-purpose register file of a small load/store core. Its physical storage is a ring of windows, plus a small bank of global registers that every window sees. A logical register number from the instruction selects a global, or one of three areas of the current window. The incoming-argument area and the private area belong to the current window. The outgoing area is the incoming-argument area of the next window down the ring. A caller therefore writes arguments into its outgoing registers, and after a call the callee finds them as its incoming parameters without any copy.

Two read ports and one write port serve one register-to-register instruction per cycle. A same-cycle read of the register being written returns the new value. A call pulse moves the current window pointer forward and a return pulse moves it back, both modulo the window count. A second pointer marks the edge of the windows that are held in memory. When a call lands the current pointer on it, an overflow trap is raised and the oldest live window is streamed out. When a return lands on it, an underflow trap is raised and the window being returned to is streamed in. Both streams use valid/ready handshakes. A transfer moves only when valid and ready are both high at a rising edge. The sender must hold its data steady while it is stalled. Each handshake moves one register, in order from incoming-argument register 0 through private register 9, with no bound on the number of stall cycles.

Top module: `rwin_regfile`

## Requirements
- R1: Logical registers 0 to 9 are globals. They hold the same storage whichever window is current.
- R2: Logical registers 10–15 are the incoming-argument area of the current window and 16–25 are its private area. Registers 26–31 are the incoming-argument area of the next window, so after a call a value written to register 26+k is read back at register 10+k.
- R3: Two independent combinational read ports and one write port are served in the same cycle. A write takes effect at the rising edge.
- R4: A read of the register being written in the same cycle returns the write data.
- R5: After reset the current pointer is 0 and the saved pointer is the window count minus 1. Both traps, spill_valid, fill_ready and xfer_done are low, and every register reads 0.
- R6: A call alone advances the current pointer by 1 and a return alone moves it back by 1, modulo the window count. A call and a return in the same cycle move nothing.
- R7: When a call makes the current pointer equal the saved pointer, ovf_trap rises in the next cycle. The window after the saved pointer is then streamed out on spill_data. The order is logical 10 to 25 of that window, as stream positions 0 to 15.
- R8: When a return makes the current pointer equal the saved pointer, unf_trap rises in the next cycle. fill_ready is then high, and 16 fill words are written into the window at the saved pointer, in the same order as a spill.
- R9: While spill_valid is high and spill_ready is low, spill_valid stays high and spill_data and the stream position do not change.
- R10: xfer_done is high for exactly one cycle, the cycle after the last handshake, and the trap is already low in that cycle. The saved pointer then moves forward by 1 after a spill and back by 1 after a fill.
- R11: While a trap is pending, call and return pulses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_addr_a | input | 5 | Logical register, read port A |
| rd_data_a | output | 32 | Read data, port A |
| rd_addr_b | input | 5 | Logical register, read port B |
| rd_data_b | output | 32 | Read data, port B |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Logical register to write |
| wr_data | input | 32 | Write data |
| call_i | input | 1 | Call pulse: move to the next window |
| ret_i | input | 1 | Return pulse: move to the previous window |
| ovf_trap | output | 1 | Overflow trap request, held until the spill ends |
| unf_trap | output | 1 | Underflow trap request, held until the fill ends |
| spill_valid | output | 1 | Spill word available |
| spill_ready | input | 1 | Handler accepts the spill word |
| spill_data | output | 32 | Spill word |
| fill_valid | input | 1 | Fill word offered |
| fill_ready | output | 1 | Block accepts a fill word |
| fill_data | input | 32 | Fill word |
| xfer_done | output | 1 | One-cycle pulse after the last spill or fill word |

## Verification
The hardest state to reach is an overflow. The ring must be walked window by window until the current pointer meets the saved pointer, and the window being spilled must still hold known values while calls are being made. The stimulus fills window 0's incoming and private registers, makes seven calls, and then drains the spill with a stall pattern. During the drain it also issues ignored call and return pulses. One further call then proves that the saved pointer has moved. A reset followed by one return reaches the underflow and fill path directly.

// File: rtl/rwin_pkg.sv
package rwin_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SPILL = 2'd1,
    ST_FILL  = 2'd2
  } win_state_e;
endpackage

// File: rtl/rwin_map.sv
// Logical register number to physical storage index.
module rwin_map #(
  parameter int NGLOB = 10,
  parameter int NPAR  = 6,
  parameter int NLOC  = 10,
  parameter int NWIN  = 8,
  parameter int AW    = 5,
  parameter int WW    = 3,
  parameter int PW    = 8
) (
  input  logic [AW-1:0] lreg,
  input  logic [WW-1:0] cwp,
  input  logic [WW-1:0] cwp_nxt,
  output logic [PW-1:0] phys
);
  localparam int WREGS = NPAR + NLOC;
  int pos;

  always_comb begin
    if (int'(lreg) < NGLOB)
      pos = int'(lreg);
    else if (int'(lreg) < NGLOB + WREGS)
      pos = NGLOB + int'(cwp) * WREGS + (int'(lreg) - NGLOB);
    else
      pos = NGLOB + int'(cwp_nxt) * WREGS + (int'(lreg) - NGLOB - WREGS);
    phys = PW'(pos);
  end
endmodule

// File: rtl/rwin_ptr.sv
// Current/saved window pointers and trap state.
module rwin_ptr
  import rwin_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int WW   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          call_i,
  input  logic          ret_i,
  input  logic          xfer_last,
  output logic [WW-1:0] cwp,
  output logic [WW-1:0] cwp_nxt,
  output logic [WW-1:0] tgt,
  output logic          spill_mode,
  output logic          fill_mode
);
  win_state_e    state_q;
  logic [WW-1:0] cwp_q, swp_q;

  function automatic logic [WW-1:0] wrap_inc(input logic [WW-1:0] p);
    return (int'(p) == NWIN - 1) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [WW-1:0] wrap_dec(input logic [WW-1:0] p);
    return (p == '0) ? WW'(NWIN - 1) : p - 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      cwp_q   <= '0;
      swp_q   <= WW'(NWIN - 1);
    end else begin
      case (state_q)
        ST_RUN: begin
          if (call_i && !ret_i) begin
            cwp_q <= wrap_inc(cwp_q);
            if (wrap_inc(cwp_q) == swp_q) state_q <= ST_SPILL;
          end else if (ret_i && !call_i) begin
            cwp_q <= wrap_dec(cwp_q);
            if (wrap_dec(cwp_q) == swp_q) state_q <= ST_FILL;
          end
        end
        ST_SPILL: if (xfer_last) begin
          swp_q   <= wrap_inc(swp_q);
          state_q <= ST_RUN;
        end
        ST_FILL: if (xfer_last) begin
          swp_q   <= wrap_dec(swp_q);
          state_q <= ST_RUN;
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end

  assign cwp        = cwp_q;
  assign cwp_nxt    = wrap_inc(cwp_q);
  assign spill_mode = (state_q == ST_SPILL);
  assign fill_mode  = (state_q == ST_FILL);
  assign tgt        = spill_mode ? wrap_inc(swp_q) : swp_q;

  // R11
  cwp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_RUN) |=> $stable(cwp_q)) else $error("cwp moved while trap pending");

  // R7
  spill_meet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spill_mode |-> (cwp_q == swp_q)) else $error("spill without pointer meeting");

  // R8
  fill_meet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_mode |-> (cwp_q == swp_q)) else $error("fill without pointer meeting");

  // R6
  both_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && call_i && ret_i) |=> $stable(cwp_q)) else $error("call+return moved cwp");
endmodule

// File: rtl/rwin_xfer.sv
// Spill/fill sequencer: one window register per handshake.
module rwin_xfer #(
  parameter int NGLOB = 10,
  parameter int WREGS = 16,
  parameter int WW    = 3,
  parameter int PW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spill_mode,
  input  logic          fill_mode,
  input  logic [WW-1:0] tgt,
  input  logic          spill_ready,
  input  logic          fill_valid,
  output logic          spill_valid,
  output logic          fill_ready,
  output logic          fill_we,
  output logic [PW-1:0] xidx,
  output logic          xfer_last,
  output logic          xfer_done
);
  localparam int CW = (WREGS > 1) ? $clog2(WREGS) : 1;

  logic [CW-1:0] cnt_q;
  logic          hs;

  assign spill_valid = spill_mode;
  assign fill_ready  = fill_mode;
  assign fill_we     = fill_mode && fill_valid;
  assign hs          = (spill_mode && spill_ready) || fill_we;
  assign xfer_last   = hs && (int'(cnt_q) == WREGS - 1);
  assign xidx        = PW'(NGLOB + int'(tgt) * WREGS + int'(cnt_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      xfer_done <= 1'b0;
    end else begin
      xfer_done <= xfer_last;
      if (xfer_last)  cnt_q <= '0;
      else if (hs)    cnt_q <= cnt_q + 1'b1;
    end
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spill_valid && !spill_ready) |=> (spill_valid && $stable(cnt_q))) else $error("spill moved under stall");

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> (!spill_mode && !fill_mode)) else $error("done while trap pending");

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done) else $error("done longer than one cycle");
endmodule

// File: rtl/rwin_store.sv
// Flat physical storage: NRD combinational read ports with bypass, core + fill write.
module rwin_store #(
  parameter int NPHYS = 138,
  parameter int DW    = 32,
  parameter int PW    = 8,
  parameter int NRD   = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NRD-1:0][PW-1:0] ridx,
  output logic [NRD-1:0][DW-1:0] rdat,
  input  logic                   we,
  input  logic [PW-1:0]          widx,
  input  logic [DW-1:0]          wdata,
  input  logic                   fwe,
  input  logic [PW-1:0]          fidx,
  input  logic [DW-1:0]          fdata
);
  logic [DW-1:0] mem [NPHYS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NPHYS; i++) mem[i] <= '0;
    end else begin
      if (we)  mem[widx] <= wdata;
      if (fwe) mem[fidx] <= fdata;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdat[g] = (we && widx == ridx[g]) ? wdata : mem[ridx[g]];
  end

  // R3
  wr_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !(fwe && fidx == widx)) |=> (mem[$past(widx)] == $past(wdata))) else $error("write lost");
endmodule

// File: rtl/rwin_regfile.sv
module rwin_regfile
  import rwin_pkg::*;
#(
  parameter int NWIN  = 8,
  parameter int NGLOB = 10,
  parameter int NPAR  = 6,
  parameter int NLOC  = 10,
  parameter int DW    = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [$clog2(NGLOB+2*NPAR+NLOC)-1:0] rd_addr_a,
  output logic [DW-1:0]                     rd_data_a,
  input  logic [$clog2(NGLOB+2*NPAR+NLOC)-1:0] rd_addr_b,
  output logic [DW-1:0]                     rd_data_b,
  input  logic                              wr_en,
  input  logic [$clog2(NGLOB+2*NPAR+NLOC)-1:0] wr_addr,
  input  logic [DW-1:0]                     wr_data,
  input  logic                              call_i,
  input  logic                              ret_i,
  output logic                              ovf_trap,
  output logic                              unf_trap,
  output logic                              spill_valid,
  input  logic                              spill_ready,
  output logic [DW-1:0]                     spill_data,
  input  logic                              fill_valid,
  output logic                              fill_ready,
  input  logic [DW-1:0]                     fill_data,
  output logic                              xfer_done
);
  localparam int LREGS = NGLOB + 2 * NPAR + NLOC;
  localparam int AW    = $clog2(LREGS);
  localparam int WREGS = NPAR + NLOC;
  localparam int NPHYS = NGLOB + NWIN * WREGS;
  localparam int PW    = $clog2(NPHYS);
  localparam int WW    = (NWIN > 1) ? $clog2(NWIN) : 1;

  logic [WW-1:0]       cwp, cwp_nxt, tgt;
  logic                spill_mode, fill_mode, xfer_last, fill_we;
  logic [PW-1:0]       xidx;
  logic [2:0][AW-1:0]  laddr;
  logic [2:0][PW-1:0]  paddr;
  logic [2:0][PW-1:0]  ridx;
  logic [2:0][DW-1:0]  rdat;

  assign laddr = {wr_addr, rd_addr_b, rd_addr_a};

  for (genvar g = 0; g < 3; g++) begin : g_map
    rwin_map #(.NGLOB(NGLOB), .NPAR(NPAR), .NLOC(NLOC), .NWIN(NWIN),
               .AW(AW), .WW(WW), .PW(PW)) u_map (
      .lreg(laddr[g]), .cwp(cwp), .cwp_nxt(cwp_nxt), .phys(paddr[g])
    );
  end

  rwin_ptr #(.NWIN(NWIN), .WW(WW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i),
    .xfer_last(xfer_last), .cwp(cwp), .cwp_nxt(cwp_nxt), .tgt(tgt),
    .spill_mode(spill_mode), .fill_mode(fill_mode)
  );

  rwin_xfer #(.NGLOB(NGLOB), .WREGS(WREGS), .WW(WW), .PW(PW)) u_xfer (
    .clk(clk), .rst_n(rst_n), .spill_mode(spill_mode), .fill_mode(fill_mode),
    .tgt(tgt), .spill_ready(spill_ready), .fill_valid(fill_valid),
    .spill_valid(spill_valid), .fill_ready(fill_ready), .fill_we(fill_we),
    .xidx(xidx), .xfer_last(xfer_last), .xfer_done(xfer_done)
  );

  assign ridx = {xidx, paddr[1], paddr[0]};

  rwin_store #(.NPHYS(NPHYS), .DW(DW), .PW(PW), .NRD(3)) u_store (
    .clk(clk), .rst_n(rst_n), .ridx(ridx), .rdat(rdat),
    .we(wr_en), .widx(paddr[2]), .wdata(wr_data),
    .fwe(fill_we), .fidx(xidx), .fdata(fill_data)
  );

  assign rd_data_a  = rdat[0];
  assign rd_data_b  = rdat[1];
  assign spill_data = rdat[2];
  assign ovf_trap   = spill_mode;
  assign unf_trap   = fill_mode;

  // R4
  bypass_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == rd_addr_a) |-> (rd_data_a == wr_data)) else $error("bypass A");

  // R5
  trap_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf_trap && unf_trap)) else $error("both traps");
endmodule

// File: tb/rwin_regfile_bench.sv
module rwin_regfile_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  rd_addr_a, rd_addr_b, wr_addr;
  logic [31:0] rd_data_a, rd_data_b, wr_data, spill_data, fill_data;
  logic        wr_en, call_i, ret_i, ovf_trap, unf_trap;
  logic        spill_valid, spill_ready, fill_valid, fill_ready, xfer_done;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  rwin_regfile u_rwin_regfile (
    .clk(clk), .rst_n(rst_n),
    .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
    .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .call_i(call_i), .ret_i(ret_i), .ovf_trap(ovf_trap), .unf_trap(unf_trap),
    .spill_valid(spill_valid), .spill_ready(spill_ready), .spill_data(spill_data),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_data(fill_data),
    .xfer_done(xfer_done)
  );

  // {logical register, value}
  localparam logic [36:0] VEC [8] = '{
    {5'd0,  32'h1111_0000}, {5'd9,  32'h1111_0009},
    {5'd10, 32'h2222_000A}, {5'd15, 32'h2222_000F},
    {5'd16, 32'h3333_0010}, {5'd25, 32'h3333_0019},
    {5'd26, 32'h4444_001A}, {5'd31, 32'h4444_001F}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0; wr_en = 0; call_i = 0; ret_i = 0; spill_ready = 0; fill_valid = 0;
    rd_addr_a = 0; rd_addr_b = 0; wr_addr = 0; wr_data = 0; fill_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic pulse(input logic c, input logic r);
    @(negedge clk);
    call_i = c; ret_i = r;
    @(negedge clk);
    call_i = 0; ret_i = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [4:0] a, input logic [31:0] exp);
    rd_addr_a = a;
    #1;
    check(tag, rd_data_a, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk); #1;
    check("R5 ovf_trap at reset", {31'b0, ovf_trap}, 0);
    check("R5 unf_trap at reset", {31'b0, unf_trap}, 0);
    check("R5 spill_valid at reset", {31'b0, spill_valid}, 0);
    check("R5 fill_ready at reset", {31'b0, fill_ready}, 0);
    check("R5 xfer_done at reset", {31'b0, xfer_done}, 0);
    rd_chk("R5 r20 zero at reset", 5'd20, 0);

    // table walk: R1 R2 R3
    for (int i = 0; i < 8; i++) wr(VEC[i][36:32], VEC[i][31:0]);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      rd_addr_a = VEC[i][36:32];
      rd_addr_b = VEC[(i + 1) % 8][36:32];
      #1;
      check("R3 port A table", rd_data_a, VEC[i][31:0]);
      check("R3 port B table", rd_data_b, VEC[(i + 1) % 8][31:0]);
    end

    // R4 bypass
    @(negedge clk);
    wr_en = 1; wr_addr = 5'd17; wr_data = 32'hBEEF_0017;
    rd_addr_a = 5'd17; rd_addr_b = 5'd16;
    #1;
    check("R4 bypass same reg", rd_data_a, 32'hBEEF_0017);
    check("R4 other reg untouched", rd_data_b, 32'h3333_0010);
    @(negedge clk);
    wr_en = 0;

    // R2 overlap, R1 globals, R6 call/return
    pulse(1, 0);
    rd_chk("R2 temps become callee params", 5'd10, 32'h4444_001A);
    rd_chk("R2 r15 from caller r31", 5'd15, 32'h4444_001F);
    rd_chk("R1 global r0 in window 1", 5'd0, 32'h1111_0000);
    rd_chk("R1 global r9 in window 1", 5'd9, 32'h1111_0009);
    rd_chk("R2 fresh window locals", 5'd17, 0);
    check("R6 no trap on call", {31'b0, ovf_trap}, 0);
    pulse(0, 1);
    rd_chk("R6 return restores caller locals", 5'd17, 32'hBEEF_0017);

    // R6 simultaneous call and return
    pulse(1, 1);
    #1;
    rd_chk("R6 call+ret ignored", 5'd17, 32'hBEEF_0017);
    check("R6 no unf after call+ret", {31'b0, unf_trap}, 0);

    // R7 overflow, R9 stall, R10 done, R11 ignore
    for (int i = 0; i < 16; i++) wr(5'(10 + i), 32'hA000 + 32'(i));
    for (int i = 0; i < 6; i++) pulse(1, 0);
    #1;
    check("R7 no trap before meeting", {31'b0, ovf_trap}, 0);
    pulse(1, 0);
    #1;
    check("R7 ovf_trap raised", {31'b0, ovf_trap}, 1);
    check("R7 spill_valid raised", {31'b0, spill_valid}, 1);
    wr(5'd16, 32'h77);
    pulse(1, 0);
    pulse(0, 1);
    begin
      int got = 0;
      int k = 0;
      logic [31:0] held = '0;
      bit stalled = 0;
      while (got < 16 && k < 200) begin
        @(negedge clk);
        spill_ready = (k % 3 != 0);
        #1;
        if (stalled) begin
          check("R9 data held under stall", spill_data, held);
          check("R9 valid held under stall", {31'b0, spill_valid}, 1);
        end
        stalled = spill_valid && !spill_ready;
        held = spill_data;
        if (spill_valid && spill_ready) begin
          check("R7 spill word order", spill_data, 32'hA000 + 32'(got));
          got++;
        end
        k++;
      end
    end
    @(negedge clk);
    spill_ready = 0;
    #1;
    check("R10 done after last spill", {31'b0, xfer_done}, 1);
    check("R10 ovf low with done", {31'b0, ovf_trap}, 0);
    @(negedge clk); #1;
    check("R10 done is one cycle", {31'b0, xfer_done}, 0);
    rd_chk("R11 pointer unmoved by ignored pulses", 5'd16, 32'h77);
    pulse(1, 0);
    #1;
    check("R10 saved pointer advanced, next call traps", {31'b0, ovf_trap}, 1);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      spill_ready = 1;
      #1;
      if (xfer_done) break;
    end
    spill_ready = 0;
    check("R10 second spill done", {31'b0, xfer_done}, 1);

    // R8 underflow and fill
    do_reset();
    pulse(0, 1);
    #1;
    check("R8 unf_trap raised", {31'b0, unf_trap}, 1);
    check("R8 fill_ready raised", {31'b0, fill_ready}, 1);
    check("R8 no spill on underflow", {31'b0, spill_valid}, 0);
    begin
      int got = 0;
      int k = 0;
      while (got < 16 && k < 200) begin
        @(negedge clk);
        fill_valid = (k % 2 == 0);
        fill_data  = 32'hF000 + 32'(got);
        #1;
        if (fill_valid && fill_ready) got++;
        k++;
      end
    end
    @(negedge clk);
    fill_valid = 0;
    #1;
    check("R10 done after last fill", {31'b0, xfer_done}, 1);
    check("R10 unf low with done", {31'b0, unf_trap}, 0);
    rd_chk("R8 filled param 0", 5'd10, 32'hF000);
    rd_chk("R8 filled local 1", 5'd17, 32'hF007);
    rd_chk("R8 filled local 9", 5'd25, 32'hF00F);
    rd_chk("R1 global intact after fill", 5'd3, 0);

    report();
    $finish;
  end
endmodule